// File: doc/BRIEF.md
# Parity-Guarded One-Hot Ring Sequencer

This block is a circular sequencer with one register bit per state. After reset a single set bit sits in the home position. On every cycle with the advance input high it moves one place up, and it wraps from the top position back to home. The intended use is as the control spine of a sequence that must survive single-event upsets in its state flops. A parity test on the state vector runs all the time. It exposes any pattern whose population count is even, which includes the all-zero vector.

When the repair input is high, a vector with even parity is replaced by the home code on the next clock edge. The upset flag is then high for exactly one cycle. When the repair input is low, the corrupted pattern keeps rotating and the flag stays high. A test mask is XORed into the next-state value for one cycle, so that upsets can be created on purpose. Corruptions that flip an even number of bits give odd parity and are not detected.

Top module: `onehot_ring_guard`

## Requirements
- R1: While `rst` is high at a clock edge, the state loads the home code: only bit 0 set, all other bits clear. After that edge `home_o` is 1 and `upset_o` is 0.
- R2: With `adv` high, no repair and a zero mask, the set bit moves from position i to position i+1 on the next edge. Position N-1 wraps to position 0.
- R3: With `adv` low, no repair and a zero mask, the state vector does not change.
- R4: `home_o` is 1 exactly when the state vector equals the home code. Any other vector, even one with bit 0 set among other bits, gives 0.
- R5: `upset_o` is 1, in the same cycle, exactly when the state vector holds an even number of ones. Zero ones counts as even.
- R6: When `heal_en` is high and `upset_o` is 1, the next state is the home code. In that cycle `adv` and `flip_mask` are ignored.
- R7: Outside reset and repair, `flip_mask` is XORed bit by bit into the next-state value: the rotated value when `adv` is high, the held value when it is low. The mask affects only the cycle in which it is applied.
- R8: With `heal_en` low, a corrupted vector keeps following the normal hold and rotate rules. An even-count pattern therefore stays flagged and never returns to the legal sequence by itself.
- R9: A mask that flips two bits of a legal vector gives an odd-count vector. That vector is not flagged and is not repaired, even with `heal_en` high.
- R10: Reset has priority over repair, advance and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Advance the ring by one position |
| heal_en | input | 1 | Allow a parity failure to restore the home state |
| flip_mask | input | N | One-cycle XOR applied to the next state (upset injection) |
| state_q | output | N | State vector, bit 0 is home |
| upset_o | output | 1 | Even parity seen on the state vector |
| home_o | output | 1 | State vector equals the home code |

## Verification
The assertions check the following on every cycle: the reset load, the one-step rotation and the hold, the repair to home after a flagged cycle, and the meaning of both flags relative to the population count of the vector. Only the bench's scenarios show the effects that build up over several cycles. These are a corrupted pattern that keeps circulating while repair is off, a double flip that parity cannot see, an all-zero vector that the repair restores, and reset winning over an active mask and repair request at the same time. A reference model with constrained-random advance, repair and mask traffic compares the whole vector every cycle.

// File: rtl/onehot_ring_guard.sv
module onehot_ring_guard #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         heal_en,
  input  logic [N-1:0] flip_mask,
  output logic [N-1:0] state_q,
  output logic         upset_o,
  output logic         home_o
);

  localparam logic [N-1:0] HOME = N'(1);

  logic [N-1:0] rot_w;
  logic [N-1:0] base_w;
  logic         heal_w;

  assign rot_w   = {state_q[N-2:0], state_q[N-1]};
  assign base_w  = adv ? rot_w : state_q;
  assign upset_o = ~(^state_q);
  assign heal_w  = heal_en & upset_o;
  assign home_o  = (state_q == HOME);

  always_ff @(posedge clk) begin
    if (rst)         state_q <= HOME;
    else if (heal_w) state_q <= HOME;
    else             state_q <= base_w ^ flip_mask;
  end

endmodule

// File: rtl/onehot_ring_guard_chk.sv
module onehot_ring_guard_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         adv,
  input logic         heal_en,
  input logic [N-1:0] flip_mask,
  input logic [N-1:0] state_q,
  input logic         upset_o,
  input logic         home_o
);

  localparam logic [N-1:0] HOME = N'(1);

  // R1
  reset_home_chk: assert property (@(posedge clk)
    rst |=> (state_q == HOME && home_o && !upset_o));

  // R2
  rotate_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !(heal_en && upset_o) && flip_mask == '0)
      |=> state_q == {$past(state_q[N-2:0]), $past(state_q[N-1])});

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !(heal_en && upset_o) && flip_mask == '0) |=> $stable(state_q));

  // R4
  home_flag_chk: assert property (@(posedge clk) disable iff (rst)
    home_o |-> (state_q[0] && $countones(state_q) == 1));

  // R5
  parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
    upset_o == ($countones(state_q) % 2 == 0));

  // R6
  heal_chk: assert property (@(posedge clk) disable iff (rst)
    (heal_en && upset_o) |=> (state_q == HOME && !upset_o));

endmodule

bind onehot_ring_guard onehot_ring_guard_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .adv(adv), .heal_en(heal_en), .flip_mask(flip_mask),
  .state_q(state_q), .upset_o(upset_o), .home_o(home_o)
);

// File: tb/onehot_ring_guard_tb.sv
module onehot_ring_guard_tb_top;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         adv = 1'b0;
  logic         heal_en = 1'b0;
  logic [N-1:0] flip_mask = '0;
  logic [N-1:0] state_q;
  logic         upset_o;
  logic         home_o;

  int checks = 0;
  int fails = 0;
  logic [N-1:0] exp_s = 8'h01;

  always #4 clk = ~clk;

  onehot_ring_guard #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .adv(adv), .heal_en(heal_en), .flip_mask(flip_mask),
    .state_q(state_q), .upset_o(upset_o), .home_o(home_o)
  );

  function automatic logic [N-1:0] model_next(logic [N-1:0] s, logic r, logic a,
                                               logic h, logic [N-1:0] m);
    logic [N-1:0] b;
    if (r) return 8'h01;
    if (h && ($countones(s) % 2 == 0)) return 8'h01;
    b = a ? {s[N-2:0], s[N-1]} : s;
    return b ^ m;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, state_q, exp_s);
    chk({tag, "/R5"}, {7'd0, upset_o}, {7'd0, ($countones(exp_s) % 2 == 0)});
    chk({tag, "/R4"}, {7'd0, home_o}, {7'd0, (exp_s == 8'h01)});
  endtask

  task automatic step(logic r, logic a, logic h, logic [N-1:0] m, string tag);
    logic [N-1:0] nxt;
    rst = r; adv = a; heal_en = h; flip_mask = m;
    nxt = model_next(exp_s, r, a, h, m);
    @(posedge clk);
    @(negedge clk);
    exp_s = nxt;
    check_all(tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0d17));
    @(negedge clk);
    step(1, 0, 0, 8'h00, "R1 reset");
    for (int i = 0; i < N; i++) step(0, 1, 0, 8'h00, "R2 rotate");
    chk("R2 wrap home", state_q, 8'h01);
    step(0, 0, 0, 8'h00, "R3 hold");
    step(0, 0, 0, 8'h00, "R3 hold");
    step(0, 1, 0, 8'h10, "R7 inject");
    chk("R7 injected pair", state_q, 8'h12);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 8'h00, "R8 lockup");
    chk("R8 flagged", {7'd0, upset_o}, 8'h01);
    step(0, 1, 1, 8'h40, "R6 heal");
    chk("R6 home", state_q, 8'h01);
    step(0, 0, 0, 8'h01, "R7 zero vector");
    chk("R5 zero flagged", {7'd0, upset_o}, 8'h01);
    step(0, 1, 1, 8'h00, "R6 heal zero");
    step(0, 1, 0, 8'h00, "R2 rotate");
    step(0, 0, 1, 8'h81, "R9 double flip");
    chk("R9 odd three", state_q, 8'h83);
    step(0, 1, 1, 8'h00, "R9 not healed");
    chk("R9 no flag", {7'd0, upset_o}, 8'h00);
    step(1, 1, 1, 8'hFF, "R10 reset priority");
    chk("R10 home", state_q, 8'h01);
    step(0, 0, 1, 8'h01, "R7 clear home");
    step(1, 1, 1, 8'h3C, "R10 reset over heal");
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] m;
      m = '0;
      if ($urandom_range(0, 9) == 0) m[$urandom_range(0, N-1)] = 1'b1;
      if ($urandom_range(0, 29) == 0) m[$urandom_range(0, N-1)] ^= 1'b1;
      step(($urandom_range(0, 199) == 0), $urandom_range(0, 1),
           ($urandom_range(0, 3) != 0), m, "R7 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule